// File: doc/BRIEF.md
# Multi-core reset and boot controller

This block is a small memory-mapped register bank that lets software bring the secondary cores of a four-core cluster up and down, reset any core, and reset two display-engine units. Software talks to it through 32-bit word accesses inside a 4 KB window. The bank holds one control word, a reset-status word, an interrupt-mask word, four spare words and ten general-purpose words. Each secondary core owns two consecutive general-purpose words, which hold its entry address and its start argument.

A write to the control word is compared with the stored copy, and only the bits that differ cause an action. Flipping a core's enable bit emits a one-cycle start pulse, together with that core's entry address and argument, or a one-cycle stop pulse. Writing a changed value to a reset-request bit emits a one-cycle reset pulse to the matching core or display unit. The request bit always reads back as zero afterwards, so software never has to clear it. If the same write also changes that core's enable, the enable wins: the reset request is dropped and no reset pulse is sent.

Every access gets a registered response one cycle later. Out-of-range or malformed accesses are dropped and flagged. Power sequencing, boot code and interrupt generation live outside this block.

Top module: `core_boot_ctrl`

## Requirements
- R1: After synchronous reset, reads return 0x0000_0521 at word index 0 (control), 0x0000_0001 at index 1 (status), 0x0000_001F at index 2 (mask) and zero at indices 3 to 16; all pulse outputs are low.
- R2: The word index is bus_addr[11:2]. Each access with bus_valid high gets rsp_valid high in the next cycle, with the stored word of that index on rsp_rdata for a legal read.
- R3: An access to index 17 or above is ignored, raises rsp_err in the response cycle and returns zero data.
- R4: An access with bus_be other than 4'hF, or with bus_addr[1:0] not zero, is ignored, raises rsp_err and returns zero data.
- R5: Writes to indices 1 to 16 store the data unchanged. General-purpose word n (n = 1..10) sits at index 6+n.
- R6: When a control write changes bit 21+c (c = 1..3) to 1, core_start[c-1] pulses in the cycle after the write. In that cycle, boot_addr[32(c-1)+:32] holds GP word 2c+1 and boot_arg[32(c-1)+:32] holds GP word 2c+2.
- R7: When a control write changes bit 21+c to 0, core_stop[c-1] pulses in the cycle after the write.
- R8: When a control write changes bit 13+c (c = 0..3), core_rst[c] pulses in the cycle after the write and that bit reads back as 0.
- R9: If the same write changes the enable bit of core c (c = 1..3), core_rst[c] does not pulse and bit 13+c is stored as 0.
- R10: When a control write changes bit 3 or bit 12, disp_rst[0] or disp_rst[1] respectively pulses in the cycle after the write, and the bit reads back as 0.
- R11: Control bits other than the reset-request bits are stored as written. A control write that changes no bit produces no pulse.
- R12: Pulses last one cycle. A read, or the cycle after any access, shows no new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address inside the window |
| bus_be | input | 4 | Byte enables, must be all ones |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Previous access was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| core_start | output | NCORE-1 (3) | Start pulse, bit c-1 for core c |
| core_stop | output | NCORE-1 (3) | Stop pulse, bit c-1 for core c |
| core_rst | output | NCORE (4) | Per-core reset pulse |
| boot_addr | output | 32*(NCORE-1) (96) | Entry address per secondary core |
| boot_arg | output | 32*(NCORE-1) (96) | Start argument per secondary core |
| disp_rst | output | 2 | Display-unit reset pulses |

## Verification
The hardest case to reach is a single control write that flips a core's enable and also requests that core's reset. That write has to land on a known prior enable state, and the enable-first masking must be seen at the pulse outputs and in the stored word. The bench reaches it with a full sweep. For every prior enable pattern, every new enable pattern and every combination of the six reset-request bits, it first writes the prior state, then writes the new word, checks the pulses one cycle later, and reads the control word back. The same loop then rewrites the stored value, which must stay silent.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Register map (word indices)
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_STAT = 1;
  localparam int unsigned IDX_MASK = 2;
  localparam int unsigned IDX_GPR1 = 7;

  // Control word fields
  localparam int unsigned BIT_RST0   = 13; // core c reset request at 13+c
  localparam int unsigned BIT_EN0    = 21; // core c enable at 21+c (c >= 1)
  localparam int unsigned BIT_DISP_A = 3;
  localparam int unsigned BIT_DISP_B = 12;

  localparam word_t RV_CTRL = 32'h0000_0521;
  localparam word_t RV_STAT = 32'h0000_0001;
  localparam word_t RV_MASK = 32'h0000_001F;

  function automatic word_t reset_word(input int unsigned idx);
    case (idx)
      IDX_CTRL: return RV_CTRL;
      IDX_STAT: return RV_STAT;
      IDX_MASK: return RV_MASK;
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NREG   = 17,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic [IDX_W-1:0]  idx,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic              bad
);
  logic aligned;
  logic in_range;
  logic legal;

  assign idx      = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00) && (be == 4'hF);
  assign in_range = (32'(idx) < NREG);
  assign legal    = aligned && in_range;

  assign wr_ok = valid && write && legal;
  assign rd_ok = valid && !write && legal;
  assign bad   = valid && !legal;
endmodule

// File: rtl/cbc_ctrl_next.sv
module cbc_ctrl_next
  import cbc_pkg::*;
#(
  parameter int unsigned NCORE = 4
) (
  input  word_t            cur,
  input  word_t            wr,
  output word_t            nxt,
  output logic [NCORE-1:1] start,
  output logic [NCORE-1:1] stop,
  output logic [NCORE-1:0] crst,
  output logic [1:0]       drst
);
  word_t diff;
  word_t val;

  always_comb begin
    diff  = cur ^ wr;
    val   = wr;
    start = '0;
    stop  = '0;
    crst  = '0;
    drst  = '0;
    // Highest core first; an enable change swallows that core's reset request
    for (int c = NCORE - 1; c >= 1; c--) begin
      if (diff[BIT_EN0 + c]) begin
        if (wr[BIT_EN0 + c]) start[c] = 1'b1;
        else                 stop[c]  = 1'b1;
        val[BIT_RST0 + c]  = 1'b0;
        diff[BIT_RST0 + c] = 1'b0;
      end
    end
    for (int c = 0; c < NCORE; c++) begin
      if (diff[BIT_RST0 + c]) begin
        crst[c]           = 1'b1;
        val[BIT_RST0 + c] = 1'b0;
      end
    end
    if (diff[BIT_DISP_A]) begin
      drst[0]         = 1'b1;
      val[BIT_DISP_A] = 1'b0;
    end
    if (diff[BIT_DISP_B]) begin
      drst[1]         = 1'b1;
      val[BIT_DISP_B] = 1'b0;
    end
    nxt = val;
  end
endmodule

// File: rtl/cbc_regfile.sv
module cbc_regfile
  import cbc_pkg::*;
#(
  parameter int unsigned NREG  = 17,
  parameter int unsigned IDX_W = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  word_t                  wdata,
  input  logic [IDX_W-1:0]       ridx,
  output word_t                  rdata,
  output logic [NREG*WORD_W-1:0] flat
);
  word_t mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                 mem[g] <= reset_word(g);
      else if (we && (widx == IDX_W'(g)))      mem[g] <= wdata;
    end
    assign flat[g*WORD_W +: WORD_W] = mem[g];
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < NREG; g++)
      if (ridx == IDX_W'(g)) rdata = mem[g];
  end
endmodule

// File: rtl/core_boot_ctrl.sv
module core_boot_ctrl
  import cbc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NCORE  = 4,
  parameter int unsigned NGPR   = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [3:0]                bus_be,
  input  logic [31:0]               bus_wdata,
  output logic                      rsp_valid,
  output logic                      rsp_err,
  output logic [31:0]               rsp_rdata,
  output logic [NCORE-2:0]          core_start,
  output logic [NCORE-2:0]          core_stop,
  output logic [NCORE-1:0]          core_rst,
  output logic [32*(NCORE-1)-1:0]   boot_addr,
  output logic [32*(NCORE-1)-1:0]   boot_arg,
  output logic [1:0]                disp_rst
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned NREG  = IDX_GPR1 + NGPR;

  logic [IDX_W-1:0]       idx;
  logic                   wr_ok, rd_ok, bad;
  word_t                  rdat, cur_ctrl, nxt_ctrl, wsel;
  logic [NREG*WORD_W-1:0] flat;
  logic [NCORE-1:1]       start_n, stop_n;
  logic [NCORE-1:0]       crst_n;
  logic [1:0]             drst_n;
  logic                   ctrl_wr;

  cbc_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr), .be(bus_be),
    .idx(idx), .wr_ok(wr_ok), .rd_ok(rd_ok), .bad(bad)
  );

  assign cur_ctrl = flat[IDX_CTRL*WORD_W +: WORD_W];
  assign ctrl_wr  = wr_ok && (idx == IDX_W'(IDX_CTRL));

  cbc_ctrl_next #(.NCORE(NCORE)) u_next (
    .cur(cur_ctrl), .wr(bus_wdata), .nxt(nxt_ctrl),
    .start(start_n), .stop(stop_n), .crst(crst_n), .drst(drst_n)
  );

  assign wsel = ctrl_wr ? nxt_ctrl : bus_wdata;

  cbc_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(wr_ok), .widx(idx), .wdata(wsel),
    .ridx(idx), .rdata(rdat), .flat(flat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
      core_start <= '0;
      core_stop  <= '0;
      core_rst   <= '0;
      disp_rst   <= '0;
    end else begin
      rsp_valid  <= bus_valid;
      rsp_err    <= bad;
      rsp_rdata  <= rd_ok ? rdat : '0;
      core_start <= ctrl_wr ? start_n : '0;
      core_stop  <= ctrl_wr ? stop_n  : '0;
      core_rst   <= ctrl_wr ? crst_n  : '0;
      disp_rst   <= ctrl_wr ? drst_n  : '0;
    end
  end

  for (genvar c = 1; c < NCORE; c++) begin : g_boot
    localparam int unsigned AI = IDX_GPR1 + 2*c;
    always_ff @(posedge clk) begin
      if (rst) begin
        boot_addr[32*(c-1) +: 32] <= '0;
        boot_arg[32*(c-1) +: 32]  <= '0;
      end else if (ctrl_wr && start_n[c]) begin
        boot_addr[32*(c-1) +: 32] <= flat[AI*WORD_W +: WORD_W];
        boot_arg[32*(c-1) +: 32]  <= flat[(AI+1)*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/cbc_checker.sv
module cbc_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NCORE  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic [NCORE-2:0]  core_start,
  input logic [NCORE-2:0]  core_stop,
  input logic [NCORE-1:0]  core_rst,
  input logic [1:0]        disp_rst
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= seen | rst;

  assert_rsp_tracks_req_R2: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(rst) |-> (rsp_valid == $past(bus_valid)));

  assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (rst || !seen)
    rsp_err |-> (rsp_rdata == 32'h0) && rsp_valid);

  assert_pulse_from_write_R8: assert property (@(posedge clk) disable iff (rst || !seen)
    (!$past(rst) && ((|core_rst) || (|disp_rst) || (|core_start) || (|core_stop)))
      |-> $past(bus_valid && bus_write));

  assert_start_stop_apart_R7: assert property (@(posedge clk) disable iff (rst || !seen)
    (core_start & core_stop) == '0);

  assert_enable_beats_reset_R9: assert property (@(posedge clk) disable iff (rst || !seen)
    ((core_start | core_stop) & core_rst[NCORE-1:1]) == '0);

  assert_start_one_cycle_R12: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(rst) |-> ((core_start & $past(core_start)) == '0));

  assert_stop_one_cycle_R12: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(rst) |-> ((core_stop & $past(core_stop)) == '0));
endmodule

bind core_boot_ctrl cbc_checker #(.ADDR_W(ADDR_W), .NCORE(NCORE)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
  .core_start(core_start), .core_stop(core_stop), .core_rst(core_rst),
  .disp_rst(disp_rst)
);

// File: tb/core_boot_ctrl_tb.sv
module core_boot_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [2:0]  core_start, core_stop;
  logic [3:0]  core_rst;
  logic [95:0] boot_addr, boot_arg;
  logic [1:0]  disp_rst;

  always #10 clk = ~clk;

  core_boot_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .core_start(core_start), .core_stop(core_stop), .core_rst(core_rst),
    .boot_addr(boot_addr), .boot_arg(boot_arg), .disp_rst(disp_rst)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  logic        c_rv, c_err;
  logic [31:0] c_rd;
  logic [2:0]  c_st, c_sp;
  logic [3:0]  c_cr;
  logic [1:0]  c_dr;
  logic [95:0] c_ba, c_bg;
  logic [31:0] exp_reg [17];
  logic [2:0]  chg, est, esp;
  logic [3:0]  ecr;
  logic [31:0] wv, ev;

  function automatic logic [31:0] gpr(input int n);
    return 32'hC0DE_0000 | (n * 32'h111);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic wr, input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    c_rv = rsp_valid; c_err = rsp_err; c_rd = rsp_rdata;
    c_st = core_start; c_sp = core_stop; c_cr = core_rst; c_dr = disp_rst;
    c_ba = boot_addr; c_bg = boot_arg;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: pulse outputs idle after reset
    chk({core_start, core_stop, core_rst, disp_rst, rsp_valid} == '0, "R1 idle outputs",
        {core_start, core_stop, core_rst, disp_rst, rsp_valid}, 0);

    for (int i = 0; i < 17; i++)
      exp_reg[i] = (i == 0) ? 32'h521 : (i == 1) ? 32'h1 : (i == 2) ? 32'h1F : 32'h0;

    // R1/R2/R3: read every word index in the window
    for (int i = 0; i < 1024; i++) begin
      op(1'b0, 12'(i << 2), 4'hF, 32'h0);
      if (i < 17) chk(c_rv && !c_err && c_rd == exp_reg[i], "R1 reset read", {c_err, c_rd}, exp_reg[i]);
      else        chk(c_rv && c_err && c_rd == 0, "R3 out-of-range read", {c_err, c_rd}, {1'b1, 32'h0});
    end

    // R5: plain writes are stored unchanged
    for (int i = 1; i < 17; i++) begin
      exp_reg[i] = (i >= 7) ? gpr(i - 6) : (32'h5A00_0000 | i);
      op(1'b1, 12'(i << 2), 4'hF, exp_reg[i]);
      chk(c_rv && !c_err && c_rd == 0, "R2 write response", {c_err, c_rd}, 0);
    end
    for (int i = 1; i < 17; i++) begin
      op(1'b0, 12'(i << 2), 4'hF, 32'h0);
      chk(c_rd == exp_reg[i], "R5 readback", c_rd, exp_reg[i]);
    end

    // R4: partial and unaligned accesses
    op(1'b1, 12'(7 << 2), 4'h3, 32'h1234_5678);
    chk(c_err, "R4 partial write err", c_err, 1);
    op(1'b1, 12'((7 << 2) | 1), 4'hF, 32'h1234_5678);
    chk(c_err, "R4 unaligned write err", c_err, 1);
    op(1'b0, 12'(7 << 2), 4'h1, 32'h0);
    chk(c_err && c_rd == 0, "R4 partial read", {c_err, c_rd}, {1'b1, 32'h0});
    op(1'b0, 12'(7 << 2), 4'hF, 32'h0);
    chk(c_rd == exp_reg[7], "R4 word untouched", c_rd, exp_reg[7]);
    // R3: out-of-range write ignored
    op(1'b1, 12'(17 << 2), 4'hF, 32'hFFFF_FFFF);
    chk(c_err && c_cr == 0, "R3 out-of-range write", {c_err, c_cr}, {1'b1, 4'h0});
    op(1'b0, 12'(16 << 2), 4'hF, 32'h0);
    chk(c_rd == exp_reg[16], "R3 neighbour untouched", c_rd, exp_reg[16]);
    op(1'b0, 12'h0, 4'hF, 32'h0);
    chk(c_rd == 32'h521, "R3 control untouched", c_rd, 32'h521);

    // Control sweep: prior enables x new enables x reset requests
    for (int o = 0; o < 8; o++) begin
      for (int n = 0; n < 8; n++) begin
        for (int p = 0; p < 64; p++) begin
          op(1'b1, 12'h0, 4'hF, 32'h521 | (32'(o) << 22));
          wv  = 32'h521 | (32'(n) << 22) | (32'(p & 15) << 13)
              | (32'((p >> 4) & 1) << 3) | (32'((p >> 5) & 1) << 12);
          chg = 3'(o ^ n);
          est = 3'(~o & n);
          esp = 3'(o & ~n);
          ecr = 4'(p & 15) & ~{chg, 1'b0};
          ev  = 32'h521 | (32'(n) << 22);
          op(1'b1, 12'h0, 4'hF, wv);
          chk(c_st == est, "R6 start pulse", c_st, est);
          chk(c_sp == esp, "R7 stop pulse", c_sp, esp);
          chk(c_cr == ecr, "R8/R9 core reset pulse", c_cr, ecr);
          chk(c_dr == 2'(p >> 4), "R10 display reset", c_dr, 2'(p >> 4));
          for (int c = 1; c < 4; c++)
            if (est[c-1])
              chk(c_ba[32*(c-1) +: 32] == gpr(2*c+1) && c_bg[32*(c-1) +: 32] == gpr(2*c+2),
                  "R6 boot address and argument", {c_ba[32*(c-1) +: 32], c_bg[32*(c-1) +: 32]},
                  {gpr(2*c+1), gpr(2*c+2)});
          op(1'b0, 12'h0, 4'hF, 32'h0);
          chk(c_rd == ev, "R11 control readback (R8 R9 R10 bits zero)", c_rd, ev);
          chk({c_st, c_sp, c_cr, c_dr} == 0, "R12 no pulse on read", {c_st, c_sp, c_cr, c_dr}, 0);
          op(1'b1, 12'h0, 4'hF, ev);
          chk({c_st, c_sp, c_cr, c_dr} == 0, "R11 unchanged write silent", {c_st, c_sp, c_cr, c_dr}, 0);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule